// File: doc/BRIEF.md
# Dual-Path Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and drives two request lines toward a processor: a normal interrupt request and a fast interrupt request. Both lines look at the same raw source vector, and each is gated by its own enable mask. A request line is high while any raw source that its mask lets through is high. The outputs are registered, so they follow a change in a source level or a mask one clock later.

Software reaches the block over a simple word-addressed register bus. A mask is never written whole. One word ORs ones into it, and a second word clears the bits written as one. This lets independent drivers enable or disable their own sources without a read-modify-write race. Source 0 carries an extra software latch: writing to one word raises it and writing to another drops it, so software can post an interrupt to itself.

The register bus has no wait states. On a write, the select, write flag, word address and data are sampled at the clock edge. On a read, the data is combinational from the current word address while select is high and the write flag is low.

Top module: `dual_path_intc`

## Requirements
- R1: After reset both enable masks and the software latch are zero, both request outputs are low, and every word reads zero while all sources are low.
- R2: Reading word 1 returns the raw vector. Raw bit n equals source input n for n ≥ 1, and raw bit 0 is the OR of source input 0 and the software latch.
- R3: Reading word 0 returns the raw vector ANDed with the normal-path mask. Reading word 8 returns the raw vector ANDed with the fast-path mask.
- R4: A write to word 2 ORs the data into the normal-path mask. A write to word 3 clears the mask bits where the data is one. Reading word 2 returns the normal-path mask.
- R5: Words 9, 10 and 11 repeat words 1, 2 and 3 for the fast path: word 9 reads the raw vector, word 10 sets fast-path mask bits (and reads back the mask), and word 11 clears them.
- R6: A write to word 4 with data bit 0 at one sets the software latch. A write to word 5 with data bit 0 at one clears it. Either write with bit 0 at zero leaves the latch as it was. Reading word 4 returns raw bit 0 in bit 0 and zero in bits 31:1.
- R7: The normal request output is high one clock after the raw vector ANDed with the normal-path mask is nonzero, and low one clock after it is zero. The fast request output follows the same rule with the fast-path mask.
- R8: Words 3, 5 and 11 read as zero. Writes to words 0, 1, 8 and 9 change no mask and do not change the software latch.
- R9: Words 6, 7 and 12 to 15 read as zero, and writes to them change no mask and do not change the software latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level-sensitive interrupt source inputs |
| acc_sel | input | 1 | Register access select |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data; zero when no read is selected |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is raw bit 0 held high by the software latch alone, with its source input low, while one mask passes bit 0 and the other blocks it. The other hard case is the same bit driven by both the input and the latch, then released one driver at a time. In that state only one request line may rise, and the word-4 readback must stay correct as each driver drops. The random stimulus mixes set and clear writes on the latch words with source vectors that often reduce to a lone bit 0. Directed steps build the both-drivers case and release the input and the latch in turn.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    W_NSTAT  = 4'd0,
    W_NRAW   = 4'd1,
    W_NSET   = 4'd2,
    W_NCLR   = 4'd3,
    W_SWSET  = 4'd4,
    W_SWCLR  = 4'd5,
    W_FSTAT  = 4'd8,
    W_FRAW   = 4'd9,
    W_FSET   = 4'd10,
    W_FCLR   = 4'd11
  } word_e;

  localparam int unsigned NPATH = 2;
  localparam int unsigned P_NORM = 0;
  localparam int unsigned P_FAST = 1;
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  function automatic logic [W-1:0] mask_next(logic [W-1:0] cur, logic s, logic c,
                                             logic [W-1:0] d);
    logic [W-1:0] n;
    n = cur;
    if (s) n = n | d;
    if (c) n = n & ~d;
    return n;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= mask_next(mask, set_stb, clr_stb, wdata);
  end
endmodule

// File: rtl/intc_soft_latch.sv
module intc_soft_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  output logic latch_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= 1'b0;
    else if (set_stb) latch_q <= 1'b1;
    else if (clr_stb) latch_q <= 1'b0;
  end
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw,
  input  logic [W-1:0] mask,
  output logic         pend,
  output logic         req_q
);
  function automatic logic any_passed(logic [W-1:0] r, logic [W-1:0] m);
    return |(r & m);
  endfunction

  assign pend = any_passed(raw, mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= pend;
  end
endmodule

// File: rtl/intc_read_mux.sv
module intc_read_mux
  import intc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [W-1:0]      raw,
  input  logic [W-1:0]      norm_mask,
  input  logic [W-1:0]      fast_mask,
  output logic [W-1:0]      rdata
);
  logic [W-1:0] sel_val;

  always_comb begin
    unique case (rd_addr)
      W_NSTAT: sel_val = raw & norm_mask;
      W_NRAW:  sel_val = raw;
      W_NSET:  sel_val = norm_mask;
      W_SWSET: sel_val = {{(W-1){1'b0}}, raw[0]};
      W_FSTAT: sel_val = raw & fast_mask;
      W_FRAW:  sel_val = raw;
      W_FSET:  sel_val = fast_mask;
      default: sel_val = '0;
    endcase
  end

  assign rdata = rd_en ? sel_val : '0;
endmodule

// File: rtl/dual_path_intc.sv
module dual_path_intc
  import intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic              acc_sel,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [NSRC-1:0]   acc_wdata,
  output logic [NSRC-1:0]   acc_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  logic                       wr_fire;
  logic                       rd_fire;
  logic                       soft_q;
  logic [NSRC-1:0]            raw_lvl;
  logic [NPATH-1:0]           set_stb;
  logic [NPATH-1:0]           clr_stb;
  logic [NPATH-1:0][NSRC-1:0] path_mask;
  logic [NPATH-1:0]           path_pend;
  logic [NPATH-1:0]           path_req;
  logic [NSRC-1:0]            irq_mask;
  logic [NSRC-1:0]            fiq_mask;

  assign wr_fire = acc_sel & acc_wr;
  assign rd_fire = acc_sel & ~acc_wr;

  assign set_stb[P_NORM] = wr_fire && (acc_addr == W_NSET);
  assign clr_stb[P_NORM] = wr_fire && (acc_addr == W_NCLR);
  assign set_stb[P_FAST] = wr_fire && (acc_addr == W_FSET);
  assign clr_stb[P_FAST] = wr_fire && (acc_addr == W_FCLR);

  intc_soft_latch u_soft (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_stb (wr_fire && (acc_addr == W_SWSET) && acc_wdata[0]),
    .clr_stb (wr_fire && (acc_addr == W_SWCLR) && acc_wdata[0]),
    .latch_q (soft_q)
  );

  assign raw_lvl = src_lvl | {{(NSRC-1){1'b0}}, soft_q};

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    intc_mask_reg #(.W(NSRC)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb[p]),
      .clr_stb (clr_stb[p]),
      .wdata   (acc_wdata),
      .mask    (path_mask[p])
    );
    intc_out_stage #(.W(NSRC)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .raw   (raw_lvl),
      .mask  (path_mask[p]),
      .pend  (path_pend[p]),
      .req_q (path_req[p])
    );
  end

  assign irq_mask = path_mask[P_NORM];
  assign fiq_mask = path_mask[P_FAST];
  assign irq_o    = path_req[P_NORM];
  assign fiq_o    = path_req[P_FAST];

  intc_read_mux #(.W(NSRC)) u_rd (
    .rd_en     (rd_fire),
    .rd_addr   (acc_addr),
    .raw       (raw_lvl),
    .norm_mask (irq_mask),
    .fast_mask (fiq_mask),
    .rdata     (acc_rdata)
  );
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
  parameter int unsigned NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_sel,
  input logic            acc_wr,
  input logic [3:0]      acc_addr,
  input logic [NSRC-1:0] acc_wdata,
  input logic [NSRC-1:0] acc_rdata,
  input logic [NSRC-1:0] raw_lvl,
  input logic [NSRC-1:0] irq_mask,
  input logic [NSRC-1:0] fiq_mask,
  input logic            soft_q,
  input logic            irq_o,
  input logic            fiq_o
);
  logic wr_n_set, wr_n_clr, wr_sw_set, wo_read;
  assign wr_n_set  = acc_sel && acc_wr && (acc_addr == 4'd2);
  assign wr_n_clr  = acc_sel && acc_wr && (acc_addr == 4'd3);
  assign wr_sw_set = acc_sel && acc_wr && (acc_addr == 4'd4) && acc_wdata[0];
  assign wo_read   = acc_sel && !acc_wr &&
                     (acc_addr == 4'd3 || acc_addr == 4'd5 || acc_addr == 4'd11);

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_lvl & irq_mask)) |=> irq_o); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(raw_lvl & irq_mask)) |=> !irq_o); // R7
  AST_FIQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(raw_lvl & fiq_mask)) |=> fiq_o); // R7
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n_set |=> ((irq_mask & $past(acc_wdata)) == $past(acc_wdata))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n_clr |=> ((irq_mask & $past(acc_wdata)) == '0)); // R4
  AST_SOFT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sw_set |=> soft_q); // R6
  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wo_read |-> (acc_rdata == '0)); // R8
endmodule

bind dual_path_intc intc_checker #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_sel   (acc_sel),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .raw_lvl   (raw_lvl),
  .irq_mask  (irq_mask),
  .fiq_mask  (fiq_mask),
  .soft_q    (soft_q),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o)
);

// File: tb/dual_path_intc_test.sv
`timescale 1ns/1ps
module dual_path_intc_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        acc_sel = 1'b0;
  logic        acc_wr = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic        irq_o, fiq_o;

  int checks = 0;
  int errors = 0;

  // bench model of software-visible state
  logic [31:0] m_norm = '0;
  logic [31:0] m_fast = '0;
  logic        m_soft = 1'b0;

  always #2 clk = ~clk;

  dual_path_intc uut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .acc_sel(acc_sel), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] raw_model();
    logic [31:0] r;
    r = src_lvl;
    if (m_soft) r[0] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] read_model(logic [3:0] a);
    logic [31:0] r;
    r = raw_model();
    case (a)
      4'd0:    return r & m_norm;
      4'd1:    return r;
      4'd2:    return m_norm;
      4'd4:    return {31'd0, r[0]};
      4'd8:    return r & m_fast;
      4'd9:    return r;
      4'd10:   return m_fast;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd0, 4'd8:         return "R3";
      4'd1:               return "R2";
      4'd2:               return "R4";
      4'd9, 4'd10:        return "R5";
      4'd4:               return "R6";
      4'd3, 4'd5, 4'd11:  return "R8";
      default:            return "R9";
    endcase
  endfunction

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    case (a)
      4'd2:  m_norm = m_norm | d;
      4'd3:  m_norm = m_norm & ~d;
      4'd10: m_fast = m_fast | d;
      4'd11: m_fast = m_fast & ~d;
      4'd4:  if (d[0]) m_soft = 1'b1;
      4'd5:  if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_sel = 1'b0; acc_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic read_check(logic [3:0] a);
    @(negedge clk);
    acc_sel = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1;
    check(tag_of(a), acc_rdata, read_model(a), $sformatf("read word %0d", a));
    acc_sel = 1'b0;
  endtask

  // outputs settle one clock after the last state change
  task automatic out_check();
    @(negedge clk);
    check("R7", {31'd0, irq_o}, {31'd0, |(raw_model() & m_norm)}, "irq_o");
    check("R7", {31'd0, fiq_o}, {31'd0, |(raw_model() & m_fast)}, "fiq_o");
  endtask

  task automatic all_words();
    for (int a = 0; a < 16; a++) read_check(4'(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {30'd0, fiq_o, irq_o}, 32'd0, "outputs during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {30'd0, fiq_o, irq_o}, 32'd0, "outputs after reset");
    all_words();

    // R2 raw levels and R3 masking
    src_lvl = 32'hA5A5_0F0E;
    out_check();
    all_words();
    bus_write(4'd2, 32'h0000_0F00);
    bus_write(4'd10, 32'hA000_0000);
    out_check();
    all_words();
    // R4 clear only the ones written
    bus_write(4'd3, 32'h0000_0300);
    out_check();
    read_check(4'd2);
    // R8 and R9 writes ignored
    for (int a = 0; a < 16; a++) begin
      if (a == 0 || a == 1 || a == 8 || a == 9 || a == 6 || a == 7 || a >= 12)
        bus_write(4'(a), 32'hFFFF_FFFF);
    end
    out_check();
    all_words();

    // R6 soft latch alone on bit 0, passed only by the fast path
    src_lvl = '0;
    bus_write(4'd3, 32'hFFFF_FFFF);
    bus_write(4'd11, 32'hFFFF_FFFF);
    bus_write(4'd10, 32'h0000_0001);
    out_check();
    bus_write(4'd4, 32'h0000_0000);   // bit 0 clear: no effect
    out_check();
    read_check(4'd4);
    bus_write(4'd4, 32'hFFFF_FFFF);
    out_check();
    read_check(4'd4);
    read_check(4'd1);
    src_lvl = 32'h0000_0001;          // both drivers of bit 0
    bus_write(4'd5, 32'h0000_0001);   // drop latch, input still high
    out_check();
    read_check(4'd4);
    src_lvl = '0;                     // drop input
    out_check();
    read_check(4'd4);
    bus_write(4'd4, 32'h1);
    bus_write(4'd5, 32'h0000_0000);   // bit 0 clear: latch stays
    out_check();
    read_check(4'd8);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned op = $urandom_range(0, 9);
      if (op < 3) begin
        @(negedge clk);
        case ($urandom_range(0, 2))
          0: src_lvl = '0;
          1: src_lvl = 32'd1 << $urandom_range(0, 31);
          default: src_lvl = $urandom();
        endcase
      end else begin
        logic [31:0] d;
        d = ($urandom_range(0, 1) == 0) ? $urandom() : (32'd1 << $urandom_range(0, 3));
        bus_write(4'($urandom_range(0, 15)), d);
      end
      out_check();
      read_check(4'($urandom_range(0, 15)));
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule